// File: doc/BRIEF.md
# Triple-Buffered LED Frame Store

This block sits between a pixel producer and an LED array scanner that share one clock but run at unrelated frame rates. It keeps three full frame stores, each holding one 60 by 30 picture of 24-bit RGB pixels. At any moment the three stores play three distinct roles. The writer is filling one. One holds the most recently completed picture. The reader is scanning out the third. The producer is never held back by the scanner, and the scanner is never held back by the producer. The scanner never sees a picture that is only partly written.

The producer presents a pixel with its address and a write enable. On the last pixel of a picture it raises an end-of-frame strobe. The scanner walks the array by driving a read address and gets the pixel one cycle later. It raises a frame request at the start of each scan to move to the newest completed picture. If no picture has been completed since its last request, it keeps the one it had. The three role indices are brought out as ports so that the roles can be observed.

Top module: `tri_frame_store`

## Requirements
- R1: After reset the read role is store 0, the latest role is store 1 and the write role is store 2 (role index encoding 0, 1, 2 on the 2-bit bank ports). Every read returns 24'h000000 until the scanner first takes a completed picture.
- R2: A write with wr_en high stores wr_pixel at wr_addr in the store that holds the write role in that cycle. When wr_eof is high and rd_frame_req is low, at the next edge the latest role becomes the old write store and the write role becomes the old latest store.
- R3: When rd_frame_req is high, wr_eof is low and a picture has been completed since the previous request, at the next edge the read role becomes the old latest store and the latest role becomes the old read store. The write role is unchanged.
- R4: When rd_frame_req is high and no picture has been completed since the previous request, all three roles stay as they are and the same picture is read again.
- R5: rd_pixel shows the pixel at the rd_addr presented in the previous cycle. The value is registered at the clock edge and then stays steady until the next edge.
- R6: When wr_eof and rd_frame_req are high in the same cycle, the read role becomes the store that was just completed, the write role becomes the old latest store, and the latest role becomes the old read store.
- R7: The read, latest and write role indices are always three distinct values from 0 to 2.
- R8: Writes at addresses of COLS*ROWS or above change no stored pixel. Reads at such addresses return zero.
- R9: The read role changes only on a frame request. When several pictures complete between two requests, the request takes the newest of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write the pixel on this cycle |
| wr_addr | input | ADDR_W (11) | Pixel location in the picture being written |
| wr_pixel | input | PIX_W (24) | RGB pixel to store |
| wr_eof | input | 1 | Marks the last write of a picture |
| rd_addr | input | ADDR_W (11) | Pixel location to read |
| rd_frame_req | input | 1 | Scanner starts a new picture |
| rd_pixel | output | PIX_W (24) | Pixel read, one cycle after rd_addr |
| rd_bank | output | 2 | Store holding the read role |
| lat_bank | output | 2 | Store holding the latest role |
| wr_bank | output | 2 | Store holding the write role |

## Verification
The main function is driven with a scripted mix of whole pictures, each tagged with its own value, and frame requests. The script includes requests with no new picture (telling re-reading apart from swapping), several pictures between two requests (telling "newest" apart from "first pending"), and strictly alternating writes and requests (checking the steady rotation). A directed case lands a request on the same cycle as the end-of-frame strobe, which separates the combined rotation from either single rotation. Reads at the first and last pixel, reads past the end, and a check of the one-cycle read latency round out the corner cases.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

   typedef logic [1:0] bank_idx_t;

   localparam int unsigned NUM_BANKS = 3;

   localparam bank_idx_t RST_RD_BANK  = 2'd0;
   localparam bank_idx_t RST_LAT_BANK = 2'd1;
   localparam bank_idx_t RST_WR_BANK  = 2'd2;

endpackage

// File: rtl/tfs_bank_ram.sv
module tfs_bank_ram #(
   parameter int unsigned DEPTH = 1800,
   parameter int unsigned AW    = 11,
   parameter int unsigned DW    = 24
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   generate
      if (DEPTH < 1 || DEPTH > (1 << AW)) begin : g_bad_depth
         $error("tfs_bank_ram: DEPTH does not fit AW");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];

   // Single write port, registered read port.
   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/tfs_role_rotator.sv
module tfs_role_rotator
   import tfs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      frame_done,
   input  logic      frame_req,
   output bank_idx_t rd_idx,
   output bank_idx_t lat_idx,
   output bank_idx_t wr_idx,
   output logic      blank
);

   // fresh_q: a picture has completed that the reader has not yet taken
   logic fresh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_idx  <= RST_RD_BANK;
         lat_idx <= RST_LAT_BANK;
         wr_idx  <= RST_WR_BANK;
         fresh_q <= 1'b0;
         blank   <= 1'b1;
      end else begin
         unique case ({frame_done, frame_req})
            2'b10: begin
               lat_idx <= wr_idx;
               wr_idx  <= lat_idx;
               fresh_q <= 1'b1;
            end
            2'b01: begin
               if (fresh_q) begin
                  rd_idx  <= lat_idx;
                  lat_idx <= rd_idx;
                  fresh_q <= 1'b0;
                  blank   <= 1'b0;
               end
            end
            2'b11: begin
               rd_idx  <= wr_idx;
               wr_idx  <= lat_idx;
               lat_idx <= rd_idx;
               fresh_q <= 1'b0;
               blank   <= 1'b0;
            end
            default: begin
            end
         endcase
      end
   end

endmodule

// File: rtl/tri_frame_store.sv
module tri_frame_store
   import tfs_pkg::*;
#(
   parameter int unsigned COLS   = 60,
   parameter int unsigned ROWS   = 30,
   parameter int unsigned PIX_W  = 24,
   parameter int unsigned DEPTH  = COLS * ROWS,
   parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [PIX_W-1:0]  wr_pixel,
   input  logic              wr_eof,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_frame_req,
   output logic [PIX_W-1:0]  rd_pixel,
   output logic [1:0]        rd_bank,
   output logic [1:0]        lat_bank,
   output logic [1:0]        wr_bank
);

   localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(DEPTH);

   generate
      if (COLS < 1 || ROWS < 1) begin : g_bad_geom
         $error("tri_frame_store: empty picture");
      end
      if (PIX_W < 1) begin : g_bad_pix
         $error("tri_frame_store: PIX_W must be positive");
      end
      if (DEPTH != COLS * ROWS) begin : g_bad_depth
         $error("tri_frame_store: DEPTH must equal COLS*ROWS");
      end
      if ((1 << ADDR_W) < DEPTH) begin : g_bad_aw
         $error("tri_frame_store: ADDR_W too narrow");
      end
   endgenerate

   bank_idx_t rd_idx, lat_idx, wr_idx;
   logic      blank;

   tfs_role_rotator u_rot (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_done (wr_eof),
      .frame_req  (rd_frame_req),
      .rd_idx     (rd_idx),
      .lat_idx    (lat_idx),
      .wr_idx     (wr_idx),
      .blank      (blank)
   );

   // Address range guards
   logic              wr_in_range, rd_in_range;
   logic [ADDR_W-1:0] wr_addr_safe, rd_addr_safe;

   always_comb begin
      wr_in_range  = {1'b0, wr_addr} < LIMIT;
      rd_in_range  = {1'b0, rd_addr} < LIMIT;
      wr_addr_safe = wr_in_range ? wr_addr : '0;
      rd_addr_safe = rd_in_range ? rd_addr : '0;
   end

   logic [PIX_W-1:0] bank_q [NUM_BANKS];

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic bank_we;
         assign bank_we = wr_en && wr_in_range && (wr_idx == bank_idx_t'(b));
         tfs_bank_ram #(
            .DEPTH (DEPTH),
            .AW    (ADDR_W),
            .DW    (PIX_W)
         ) u_ram (
            .clk   (clk),
            .we    (bank_we),
            .waddr (wr_addr_safe),
            .wdata (wr_pixel),
            .raddr (rd_addr_safe),
            .rdata (bank_q[b])
         );
      end
   endgenerate

   // Read-side selection registered alongside the RAM read
   bank_idx_t sel_q;
   logic      zero_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= RST_RD_BANK;
         zero_q <= 1'b1;
      end else begin
         sel_q  <= rd_idx;
         zero_q <= blank || !rd_in_range;
      end
   end

   always_comb begin
      rd_pixel = '0;
      if (!zero_q) begin
         unique case (sel_q)
            2'd0:    rd_pixel = bank_q[0];
            2'd1:    rd_pixel = bank_q[1];
            2'd2:    rd_pixel = bank_q[2];
            default: rd_pixel = '0;
         endcase
      end
   end

   assign rd_bank  = rd_idx;
   assign lat_bank = lat_idx;
   assign wr_bank  = wr_idx;

endmodule

// File: rtl/tri_frame_store_chk.sv
module tri_frame_store_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_eof,
   input logic       rd_frame_req,
   input logic [1:0] rd_bank,
   input logic [1:0] lat_bank,
   input logic [1:0] wr_bank
);

   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_roles_distinct_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_bank != lat_bank) && (rd_bank != wr_bank) && (lat_bank != wr_bank)
      && (rd_bank != 2'd3) && (lat_bank != 2'd3) && (wr_bank != 2'd3));

   assert_eof_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && wr_eof && !rd_frame_req) |=>
         (lat_bank == $past(wr_bank)) && (wr_bank == $past(lat_bank))
         && (rd_bank == $past(rd_bank)));

   assert_req_swap_or_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && rd_frame_req && !wr_eof) |=>
         (wr_bank == $past(wr_bank)) &&
         ((rd_bank == $past(rd_bank)) || (rd_bank == $past(lat_bank))));

   assert_same_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && rd_frame_req && wr_eof) |=>
         (rd_bank == $past(wr_bank)) && (wr_bank == $past(lat_bank))
         && (lat_bank == $past(rd_bank)));

   assert_read_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !rd_frame_req) |=> $stable(rd_bank));

endmodule

bind tri_frame_store tri_frame_store_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_eof       (wr_eof),
   .rd_frame_req (rd_frame_req),
   .rd_bank      (rd_bank),
   .lat_bank     (lat_bank),
   .wr_bank      (wr_bank)
);

// File: tb/tri_frame_store_tb.sv
`timescale 1ns/1ps
module tri_frame_store_tb;

   localparam int COLS  = 60;
   localparam int ROWS  = 30;
   localparam int DEPTH = COLS * ROWS;
   localparam int AW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_en, wr_eof, rd_frame_req;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [23:0]   wr_pixel, rd_pixel;
   logic [1:0]    rd_bank, lat_bank, wr_bank;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   tri_frame_store u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_pixel     (wr_pixel),
      .wr_eof       (wr_eof),
      .rd_addr      (rd_addr),
      .rd_frame_req (rd_frame_req),
      .rd_pixel     (rd_pixel),
      .rd_bank      (rd_bank),
      .lat_bank     (lat_bank),
      .wr_bank      (wr_bank)
   );

   // Vector: [31:30] op (0 request, 1 write picture), [29:22] picture tag,
   // [21:20] rd, [19:18] latest, [17:16] write, [15:8] tag expected on read
   localparam int NV = 9;
   localparam logic [31:0] VEC [NV] = '{
      {2'd0, 8'h00, 2'd0, 2'd1, 2'd2, 8'h00, 8'h00},
      {2'd1, 8'h11, 2'd0, 2'd2, 2'd1, 8'h00, 8'h00},
      {2'd0, 8'h00, 2'd2, 2'd0, 2'd1, 8'h11, 8'h00},
      {2'd0, 8'h00, 2'd2, 2'd0, 2'd1, 8'h11, 8'h00},
      {2'd1, 8'h22, 2'd2, 2'd1, 2'd0, 8'h11, 8'h00},
      {2'd1, 8'h33, 2'd2, 2'd0, 2'd1, 8'h11, 8'h00},
      {2'd0, 8'h00, 2'd0, 2'd2, 2'd1, 8'h33, 8'h00},
      {2'd1, 8'h44, 2'd0, 2'd1, 2'd2, 8'h33, 8'h00},
      {2'd0, 8'h00, 2'd1, 2'd0, 2'd2, 8'h44, 8'h00}
   };

   function automatic logic [23:0] pix_of(input logic [7:0] tag, input int a);
      return (tag == 8'h00) ? 24'h0 : {tag, 16'(a)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_picture(input logic [7:0] tag, input bit req_on_last);
      for (int a = 0; a < DEPTH; a++) begin
         @(negedge clk);
         wr_en        = 1'b1;
         wr_addr      = AW'(a);
         wr_pixel     = pix_of(tag, a);
         wr_eof       = (a == DEPTH - 1);
         rd_frame_req = req_on_last && (a == DEPTH - 1);
      end
      @(negedge clk);
      wr_en = 1'b0; wr_eof = 1'b0; rd_frame_req = 1'b0;
   endtask

   task automatic request_frame();
      @(negedge clk);
      rd_frame_req = 1'b1;
      @(negedge clk);
      rd_frame_req = 1'b0;
   endtask

   task automatic read_pix(input int a, output logic [23:0] v);
      @(negedge clk);
      rd_addr = AW'(a);
      @(posedge clk);
      #1 v = rd_pixel;
   endtask

   task automatic check_roles(input string req, input logic [1:0] er,
                              input logic [1:0] el, input logic [1:0] ew);
      @(negedge clk);
      chk(rd_bank == er && lat_bank == el && wr_bank == ew, req,
          {26'd0, rd_bank, lat_bank, wr_bank}, {26'd0, er, el, ew});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [23:0] v;
      logic [31:0] e;
      rst_n = 1'b0; wr_en = 1'b0; wr_eof = 1'b0; rd_frame_req = 1'b0;
      wr_addr = '0; rd_addr = '0; wr_pixel = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset roles and black output
      check_roles("R1 reset roles", 2'd0, 2'd1, 2'd2);
      read_pix(5, v);
      chk(v == 24'h0, "R1 black after reset", {8'd0, v}, 32'd0);

      // Table walk: R2, R3, R4, R9
      for (int i = 0; i < NV; i++) begin
         e = VEC[i];
         if (e[31:30] == 2'd1) send_picture(e[29:22], 1'b0);
         else                  request_frame();
         check_roles($sformatf("R2/R3/R4/R9 roles step %0d", i),
                     e[21:20], e[19:18], e[17:16]);
         read_pix(0, v);
         chk(v == pix_of(e[15:8], 0), $sformatf("R2/R9 pixel 0 step %0d", i),
             {8'd0, v}, {8'd0, pix_of(e[15:8], 0)});
         read_pix(DEPTH - 1, v);
         chk(v == pix_of(e[15:8], DEPTH - 1),
             $sformatf("R2/R9 last pixel step %0d", i),
             {8'd0, v}, {8'd0, pix_of(e[15:8], DEPTH - 1)});
      end

      // R5: output holds old address data until the next edge
      read_pix(DEPTH - 1, v);
      @(negedge clk);
      rd_addr = AW'(0);
      #1;
      chk(rd_pixel == pix_of(8'h44, DEPTH - 1), "R5 before edge",
          {8'd0, rd_pixel}, {8'd0, pix_of(8'h44, DEPTH - 1)});
      @(posedge clk);
      #1;
      chk(rd_pixel == pix_of(8'h44, 0), "R5 after edge",
          {8'd0, rd_pixel}, {8'd0, pix_of(8'h44, 0)});

      // R6: request on the same cycle as end of frame
      send_picture(8'h55, 1'b1);
      check_roles("R6 same-cycle roles", 2'd2, 2'd1, 2'd0);
      read_pix(7, v);
      chk(v == pix_of(8'h55, 7), "R6 same-cycle pixel", {8'd0, v},
          {8'd0, pix_of(8'h55, 7)});

      // R4: no fresh picture after the combined swap
      request_frame();
      check_roles("R4 hold after R6", 2'd2, 2'd1, 2'd0);

      // R8: out-of-range writes and reads
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(DEPTH); wr_pixel = 24'hABCDEF;
      @(negedge clk);
      wr_addr = '1;
      @(negedge clk);
      wr_en = 1'b0;
      send_picture(8'h66, 1'b0);
      request_frame();
      read_pix(DEPTH, v);
      chk(v == 24'h0, "R8 read past end", {8'd0, v}, 32'd0);
      read_pix(0, v);
      chk(v == pix_of(8'h66, 0), "R8 pixel 0 intact", {8'd0, v},
          {8'd0, pix_of(8'h66, 0)});
      // R7: roles distinct at the end
      @(negedge clk);
      chk(rd_bank != lat_bank && rd_bank != wr_bank && lat_bank != wr_bank,
          "R7 roles distinct", {26'd0, rd_bank, lat_bank, wr_bank}, 32'h06);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // R7: distinct roles sampled every cycle away from the edge
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (rd_bank == lat_bank || rd_bank == wr_bank || lat_bank == wr_bank) begin
            total++;
            bad++;
            $display("FAIL R7 roles collide actual=%0d/%0d/%0d expected=distinct",
                     rd_bank, lat_bank, wr_bank);
         end
      end
   end

endmodule